// File: doc/BRIEF.md
# Bidirectional Cascadable Row Scan Shifter

This block is the logic core of a row-select driver for an active-matrix display. A single start token enters one of two start-pulse pins and moves one row per rising edge of the shift clock along a chain of row stages. Each stage drives one row-select bit. The direction input picks which pin feeds the chain and which pin carries the token on to the next device in a cascade. The pin that is not the input is driven, and the other one is left undriven.

A mode input chooses between the full chain and a shortened chain. The shortened chain skips a fixed group of seven middle stages, and the rows of those stages stay off. An output-disable input forces every row off at once, without a clock and without touching the stored token. The cascade output takes the value of the final stage on the falling clock edge, so the next device can capture it on its following rising edge.

Top module: `gate_scan_shifter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, all stages are cleared, so every `row_on` bit reads 0. The cascade register is cleared at the next falling edge, so `pin_a_o` and `pin_b_o` read 0.
- R2: With `dir_up`=1, `pin_a_i` is captured into stage 0 (`row_on[0]`) on a rising edge. On each later rising edge the token moves one index upward, toward `row_on[N_STAGES-1]`.
- R3: With `dir_up`=0, `pin_b_i` is captured into stage `N_STAGES-1` on a rising edge. On each later rising edge the token moves one index downward, toward `row_on[0]`.
- R4: With `dir_up`=1, `pin_b_oe`=1 and `pin_a_oe`=0. With `dir_up`=0 it is the reverse. Exactly one pin enable is high at any time.
- R5: With `full_mode`=0, indices 128 to 134 are bypassed. The token goes from index 127 straight to index 135 when shifting up, and from 135 straight to 127 when shifting down. A scan then takes 256 steps instead of 263.
- R6: With `full_mode`=0, `row_on[134:128]` are 0 at once, without waiting for a clock edge. At the next rising edge the stages at those indices are cleared.
- R7: The cascade output (`pin_b_o` when shifting up, `pin_a_o` when shifting down) takes the value of the final stage in the current direction on each falling edge. It therefore rises half a period after the final row turns on, and stays high for one full period.
- R8: With `out_dis`=1, every `row_on` bit is 0 at once, without waiting for a clock edge. Shifting and the cascade output carry on unchanged. When `out_dis` returns to 0, the row of the current token reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages move on its rising edge, cascade on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | 1: enter on pin A and shift upward; 0: enter on pin B and shift downward |
| full_mode | input | 1 | 1: all stages active; 0: seven middle stages bypassed |
| out_dis | input | 1 | 1: all row outputs forced off |
| pin_a_i | input | 1 | Start-pulse pin A, input side |
| pin_a_o | output | 1 | Start-pulse pin A, cascade value |
| pin_a_oe | output | 1 | Start-pulse pin A, drive enable |
| pin_b_i | input | 1 | Start-pulse pin B, input side |
| pin_b_o | output | 1 | Start-pulse pin B, cascade value |
| pin_b_oe | output | 1 | Start-pulse pin B, drive enable |
| row_on | output | N_STAGES | Row-select bits, 1 = gate on |

## Verification
A single token is sent through the chain in each of the four combinations of direction and mode. On every step the whole `row_on` vector is compared with a one-hot word. This shows whether the ordering is wrong, whether the wrong pin feeds the chain, and whether the bypass joint is misplaced or missing. A fifth run repeats the upward full scan with the outputs disabled, so all rows must stay dark while the cascade pulse still arrives on time; this shows that the mask does not touch the shift state. Directed cases cover reset in the middle of a scan, a toggle of `out_dis` within a single clock period, and a change to the short mode while the token sits in a bypassed stage. The cascade is sampled both before and after the falling edge to pin down its half-period offset.

// File: rtl/gss_pkg.sv
package gss_pkg;

  typedef enum logic {
    GSS_DOWN = 1'b0,
    GSS_UP   = 1'b1
  } gss_dir_e;

  // true when a stage index lies inside the bypassable middle group
  function automatic bit gss_in_bypass(int idx, int first, int count);
    return (idx >= first) && (idx < first + count);
  endfunction

endpackage

// File: rtl/gss_stage_chain.sv
module gss_stage_chain
  import gss_pkg::*;
#(
  parameter int N_STAGES   = 263,
  parameter int SKIP_FIRST = 128,
  parameter int SKIP_COUNT = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  gss_dir_e            dir,
  input  logic                full_mode,
  input  logic                din,
  output logic [N_STAGES-1:0] stage_q
);

  localparam int SKIP_LAST = SKIP_FIRST + SKIP_COUNT - 1;
  localparam int JOIN_LO   = SKIP_FIRST - 1;
  localparam int JOIN_HI   = SKIP_LAST + 1;

  logic [N_STAGES-1:0] stage_d;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    logic up_src;
    logic dn_src;
    logic sel_src;

    // source when shifting toward higher indices
    if (i == 0) begin : g_up_head
      assign up_src = din;
    end else if (i == JOIN_HI) begin : g_up_join
      assign up_src = full_mode ? stage_q[i-1] : stage_q[JOIN_LO];
    end else begin : g_up_mid
      assign up_src = stage_q[i-1];
    end

    // source when shifting toward lower indices
    if (i == N_STAGES - 1) begin : g_dn_head
      assign dn_src = din;
    end else if (i == JOIN_LO) begin : g_dn_join
      assign dn_src = full_mode ? stage_q[i+1] : stage_q[JOIN_HI];
    end else begin : g_dn_mid
      assign dn_src = stage_q[i+1];
    end

    assign sel_src = (dir == GSS_UP) ? up_src : dn_src;

    // bypassed stages are flushed while the short chain is selected
    if (gss_in_bypass(i, SKIP_FIRST, SKIP_COUNT)) begin : g_bypassable
      assign stage_d[i] = full_mode & sel_src;
    end else begin : g_fixed
      assign stage_d[i] = sel_src;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

endmodule

// File: rtl/gss_start_port.sv
module gss_start_port
  import gss_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  gss_dir_e dir,
  input  logic     pin_a_i,
  input  logic     pin_b_i,
  input  logic     low_end,
  input  logic     high_end,
  output logic     din,
  output logic     pin_a_o,
  output logic     pin_a_oe,
  output logic     pin_b_o,
  output logic     pin_b_oe
);

  logic casc_q;
  logic tail;

  // the chain input is the pin that is not driving
  assign din  = (dir == GSS_UP) ? pin_a_i : pin_b_i;
  assign tail = (dir == GSS_UP) ? high_end : low_end;

  // launched half a period after the stages move
  always_ff @(negedge clk) begin
    if (rst) begin
      casc_q <= 1'b0;
    end else begin
      casc_q <= tail;
    end
  end

  assign pin_a_oe = (dir == GSS_DOWN);
  assign pin_b_oe = (dir == GSS_UP);
  assign pin_a_o  = casc_q;
  assign pin_b_o  = casc_q;

endmodule

// File: rtl/gss_row_gate.sv
module gss_row_gate
  import gss_pkg::*;
#(
  parameter int N_STAGES   = 263,
  parameter int SKIP_FIRST = 128,
  parameter int SKIP_COUNT = 7
) (
  input  logic [N_STAGES-1:0] stage_q,
  input  logic                full_mode,
  input  logic                out_dis,
  output logic [N_STAGES-1:0] row_on
);

  for (genvar i = 0; i < N_STAGES; i++) begin : g_row
    if (gss_in_bypass(i, SKIP_FIRST, SKIP_COUNT)) begin : g_masked
      assign row_on[i] = stage_q[i] & full_mode & ~out_dis;
    end else begin : g_plain
      assign row_on[i] = stage_q[i] & ~out_dis;
    end
  end

endmodule

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter
  import gss_pkg::*;
#(
  parameter int N_STAGES   = 263,
  parameter int SKIP_FIRST = 128,
  parameter int SKIP_COUNT = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dir_up,
  input  logic                full_mode,
  input  logic                out_dis,
  input  logic                pin_a_i,
  output logic                pin_a_o,
  output logic                pin_a_oe,
  input  logic                pin_b_i,
  output logic                pin_b_o,
  output logic                pin_b_oe,
  output logic [N_STAGES-1:0] row_on
);

  gss_dir_e            dir;
  logic                din;
  logic [N_STAGES-1:0] stage_q;

  assign dir = gss_dir_e'(dir_up);

  gss_start_port port_i (
    .clk      (clk),
    .rst      (rst),
    .dir      (dir),
    .pin_a_i  (pin_a_i),
    .pin_b_i  (pin_b_i),
    .low_end  (stage_q[0]),
    .high_end (stage_q[N_STAGES-1]),
    .din      (din),
    .pin_a_o  (pin_a_o),
    .pin_a_oe (pin_a_oe),
    .pin_b_o  (pin_b_o),
    .pin_b_oe (pin_b_oe)
  );

  gss_stage_chain #(
    .N_STAGES   (N_STAGES),
    .SKIP_FIRST (SKIP_FIRST),
    .SKIP_COUNT (SKIP_COUNT)
  ) chain_i (
    .clk       (clk),
    .rst       (rst),
    .dir       (dir),
    .full_mode (full_mode),
    .din       (din),
    .stage_q   (stage_q)
  );

  gss_row_gate #(
    .N_STAGES   (N_STAGES),
    .SKIP_FIRST (SKIP_FIRST),
    .SKIP_COUNT (SKIP_COUNT)
  ) gate_i (
    .stage_q   (stage_q),
    .full_mode (full_mode),
    .out_dis   (out_dis),
    .row_on    (row_on)
  );

endmodule

// File: rtl/gate_scan_shifter_chk.sv
module gate_scan_shifter_chk #(
  parameter int N_STAGES   = 263,
  parameter int SKIP_FIRST = 128,
  parameter int SKIP_COUNT = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                dir_up,
  input logic                full_mode,
  input logic                out_dis,
  input logic                pin_a_i,
  input logic                pin_b_i,
  input logic                pin_a_o,
  input logic                pin_b_o,
  input logic                pin_a_oe,
  input logic                pin_b_oe,
  input logic [N_STAGES-1:0] row_on
);

  localparam int SKIP_LAST = SKIP_FIRST + SKIP_COUNT - 1;

  // R2: upward entry captures pin A
  p_up_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dir_up) && !out_dis) |-> (row_on[0] == $past(pin_a_i)));

  // R3: downward entry captures pin B
  p_down_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dir_up) && !out_dis) |-> (row_on[N_STAGES-1] == $past(pin_b_i)));

  // R4: exactly one start-pulse pin drives, and it is the downstream one
  p_pin_dir_r4: assert property (@(posedge clk) disable iff (rst)
    ($countones({pin_a_oe, pin_b_oe}) == 1) && (dir_up ? pin_b_oe : pin_a_oe));

  // R5: short chain joins index below and above the bypassed group
  p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dir_up) && !$past(full_mode) && !$past(out_dis) && !out_dis)
    |-> (row_on[SKIP_LAST+1] == $past(row_on[SKIP_FIRST-1])));

  // R6: bypassed rows stay dark in the short chain
  p_skip_off_r6: assert property (@(posedge clk) disable iff (rst)
    !full_mode |-> (row_on[SKIP_LAST:SKIP_FIRST] == '0));

  // R7: cascade carries the final stage of the current direction
  p_cascade_up_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dir_up && !out_dis) |-> (pin_b_o == row_on[N_STAGES-1]));

  p_cascade_down_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !dir_up && !out_dis) |-> (pin_a_o == row_on[0]));

  // R8: disable forces every row off
  p_mask_r8: assert property (@(posedge clk) disable iff (rst)
    out_dis |-> (row_on == '0));

endmodule

bind gate_scan_shifter gate_scan_shifter_chk #(
  .N_STAGES   (N_STAGES),
  .SKIP_FIRST (SKIP_FIRST),
  .SKIP_COUNT (SKIP_COUNT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .dir_up    (dir_up),
  .full_mode (full_mode),
  .out_dis   (out_dis),
  .pin_a_i   (pin_a_i),
  .pin_b_i   (pin_b_i),
  .pin_a_o   (pin_a_o),
  .pin_b_o   (pin_b_o),
  .pin_a_oe  (pin_a_oe),
  .pin_b_oe  (pin_b_oe),
  .row_on    (row_on)
);

// File: tb/gate_scan_shifter_tb_top.sv
module gate_scan_shifter_tb_top;

  localparam int CLK_PERIOD = 8;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int ROWS       = 263;
  localparam int SKIP_FIRST = 128;
  localparam int SKIP_COUNT = 7;
  localparam int N_SCEN     = 5;
  // each entry: {dir_up, full_mode, out_dis}
  localparam logic [2:0] SCEN [N_SCEN] = '{3'b110, 3'b010, 3'b100, 3'b000, 3'b111};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            dir_up = 1'b1;
  logic            full_mode = 1'b1;
  logic            out_dis = 1'b0;
  logic            pin_a_i = 1'b0;
  logic            pin_b_i = 1'b0;
  logic            pin_a_o, pin_a_oe, pin_b_o, pin_b_oe;
  logic [ROWS-1:0] row_on;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_scan_shifter #(
    .N_STAGES   (ROWS),
    .SKIP_FIRST (SKIP_FIRST),
    .SKIP_COUNT (SKIP_COUNT)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .dir_up    (dir_up),
    .full_mode (full_mode),
    .out_dis   (out_dis),
    .pin_a_i   (pin_a_i),
    .pin_a_o   (pin_a_o),
    .pin_a_oe  (pin_a_oe),
    .pin_b_i   (pin_b_i),
    .pin_b_o   (pin_b_o),
    .pin_b_oe  (pin_b_oe),
    .row_on    (row_on)
  );

  function automatic int exp_idx(int step, bit up, bit full);
    int active = full ? ROWS : ROWS - SKIP_COUNT;
    int off;
    if (step >= active) return -1;
    off = (!full && step >= SKIP_FIRST) ? step + SKIP_COUNT : step;
    return up ? off : ROWS - 1 - off;
  endfunction

  function automatic logic [ROWS-1:0] onehot(int idx);
    logic [ROWS-1:0] v = '0;
    if (idx >= 0) v[idx] = 1'b1;
    return v;
  endfunction

  task automatic chk_vec(string req, logic [ROWS-1:0] act, logic [ROWS-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s row_on actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // called at a quarter period after a rising edge; returns likewise
  task automatic reset_chain();
    rst = 1'b1;
    @(posedge clk); #QTR;
    rst = 1'b0;
  endtask

  task automatic inject(bit up);
    if (up) pin_a_i = 1'b1; else pin_b_i = 1'b1;
  endtask

  task automatic step_cycle();
    @(posedge clk); #QTR;
  endtask

  task automatic run_scan(bit up, bit full, bit dis);
    int  active = full ? ROWS : ROWS - SKIP_COUNT;
    string tag  = !full ? "R5" : (up ? "R2" : "R3");
    dir_up = up; full_mode = full; out_dis = dis;
    pin_a_i = 1'b0; pin_b_i = 1'b0;
    reset_chain();
    chk_bit("R4", "pin_a_oe", pin_a_oe, !up);
    chk_bit("R4", "pin_b_oe", pin_b_oe, up);
    inject(up);
    for (int step = 0; step <= active; step++) begin
      step_cycle();
      if (step == 0) begin pin_a_i = 1'b0; pin_b_i = 1'b0; end
      chk_vec(dis ? "R8" : tag, row_on, dis ? '0 : onehot(exp_idx(step, up, full)));
      chk_bit("R7", "cascade", up ? pin_b_o : pin_a_o, step == active);
      if (step == active - 1) begin
        // falling edge launches the cascade half a period later
        #(CLK_PERIOD/2);
        chk_bit("R7", "cascade after fall", up ? pin_b_o : pin_a_o, 1'b1);
      end
    end
    step_cycle();
    chk_bit("R7", "cascade end", up ? pin_b_o : pin_a_o, 1'b0);
    out_dis = 1'b0;
  endtask

  initial begin
    // reset state: R1
    repeat (2) @(posedge clk);
    #QTR;
    chk_vec("R1", row_on, '0);
    chk_bit("R1", "pin_a_o", pin_a_o, 1'b0);
    chk_bit("R1", "pin_b_o", pin_b_o, 1'b0);
    rst = 1'b0;

    for (int s = 0; s < N_SCEN; s++) begin
      run_scan(SCEN[s][2], SCEN[s][1], SCEN[s][0]);
    end

    // R8: disable within one period, token undisturbed
    dir_up = 1'b1; full_mode = 1'b1;
    reset_chain();
    inject(1'b1);
    for (int step = 0; step <= 5; step++) begin
      step_cycle();
      if (step == 0) pin_a_i = 1'b0;
    end
    chk_vec("R2", row_on, onehot(5));
    out_dis = 1'b1; #1;
    chk_vec("R8", row_on, '0);
    out_dis = 1'b0; #1;
    chk_vec("R8", row_on, onehot(5));

    // R1: reset in the middle of a scan
    step_cycle();
    rst = 1'b1;
    step_cycle();
    chk_vec("R1", row_on, '0);
    #(CLK_PERIOD/2);
    chk_bit("R1", "pin_b_o", pin_b_o, 1'b0);
    rst = 1'b0;
    step_cycle();

    // R6: switch to short chain while the token sits in a bypassed stage
    reset_chain();
    inject(1'b1);
    for (int step = 0; step <= 130; step++) begin
      step_cycle();
      if (step == 0) pin_a_i = 1'b0;
    end
    chk_vec("R2", row_on, onehot(130));
    full_mode = 1'b0; #1;
    chk_vec("R6", row_on, '0);
    step_cycle();
    full_mode = 1'b1; #1;
    chk_vec("R6", row_on, '0);
    repeat (3) step_cycle();
    chk_vec("R6", row_on, '0);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule